// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block guards a bank of peripheral registers against stray writes. It leaves reset closed. It opens only after software writes two fixed 32-bit key values, in order, to two dedicated key addresses. While the gate is closed, write strobes aimed at the protected registers are suppressed without error. Once the gate is open, those strobes pass through in the same cycle.

Software learns the gate state by reading a status bit in the control register. Reads are never blocked. If the status bit is already set, software can skip the key writes. The gate stays open until the next reset.

The key-match machine tolerates unrelated traffic between the two key writes. A wrong value, or a second key that arrives without a good first key, sends the sequence back to its start.

Top module: `keygate_top`

## Requirements
- R1: While reset is asserted and after it is released, the gate is closed, the protected write strobe is low and the status bit reads 0.
- R2: Two writes open the gate, and the status bit reads 1 from the cycle after the second write. The first writes 0x83E70B13 to address 0x70. The second, later, writes 0x95A4F1E0 to address 0x74.
- R3: A correct second-key write (0x74) that is not preceded by an accepted first key leaves the gate closed.
- R4: A wrong value written to either key address after an accepted first key returns the sequence to its start, so a following correct second key does not open the gate.
- R5: Writes to addresses other than the two key addresses, made between the two key writes, do not disturb the sequence.
- R6: While the gate is closed, the protected write strobe stays low for every write.
- R7: While the gate is open, the protected write strobe equals the write enable in the same cycle for every address except 0x70 and 0x74, which never raise it.
- R8: Once open, the gate stays open until reset, whatever is later written to the key addresses.
- R9: A read of address 0x50 returns the gate state in bit 23 with all other bits 0; a read of any other address returns 0. Reads are never gated.
- R10: Repeating the correct first key after it has been accepted keeps the sequence armed for the second key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe from the bus port |
| wrAddr | input | 8 | Byte address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Byte address being read |
| rdData | output | 32 | Read data (status register only, else 0) |
| protWrEn | output | 1 | Gated write strobe to the protected registers |

## Verification
The hardest situations to reach from the ports are the half-armed state and its exits. These are a wrong first key after a good one, a repeated good first key, and unrelated writes made while the machine waits for the second key. The stimulus opens each of these paths by writing a good first key and then choosing the next write. It follows each path with a correct second key, so the status read and the gated strobe show whether the sequence was reset or kept. A final reset after the gate opens shows that it closes again.

// File: rtl/keygate_pkg.sv
package keygate_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } gateState_t;

  // decode strobes from datapath to control
  typedef struct packed {
    logic key0Good;
    logic key0Bad;
    logic key1Good;
    logic key1Bad;
  } keyEvt_t;

  // control strobes back to datapath
  typedef struct packed {
    logic gateOpen;
  } gateCtl_t;
endpackage

// File: rtl/keygate_ctrl.sv
module keygate_ctrl
  import keygate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  keyEvt_t  evt,
  output gateCtl_t ctl
);
  gateState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LOCKED: if (evt.key0Good) stateNext = ST_ARMED;
      ST_ARMED: begin
        if (evt.key1Good) stateNext = ST_OPEN;
        else if (evt.key0Bad || evt.key1Bad) stateNext = ST_LOCKED;
      end
      ST_OPEN:  stateNext = ST_OPEN;
      default:  stateNext = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNext;
  end

  assign ctl.gateOpen = (state == ST_OPEN);

  // R1
  reset_closed_chk: assert property (@(posedge clk) !rstN |=> !ctl.gateOpen);
  // R8
  open_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.gateOpen |=> ctl.gateOpen);
  // R2
  open_needs_key1_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.gateOpen) |-> $past(evt.key1Good));
  // R3
  key1_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && evt.key1Good) |=> !ctl.gateOpen);
endmodule

// File: rtl/keygate_dp.sv
module keygate_dp
  import keygate_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  KEY0_ADDR  = 8'h70,
  parameter logic [7:0]  KEY1_ADDR  = 8'h74,
  parameter logic [7:0]  CTRL_ADDR  = 8'h50,
  parameter logic [31:0] KEY0_VAL   = 32'h83E7_0B13,
  parameter logic [31:0] KEY1_VAL   = 32'h95A4_F1E0,
  parameter int          STATUS_BIT = 23
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  gateCtl_t          ctl,
  output keyEvt_t           evt,
  output logic [DATA_W-1:0] rdData,
  output logic              protWrEn
);
  localparam logic [ADDR_W-1:0] K0A = ADDR_W'(KEY0_ADDR);
  localparam logic [ADDR_W-1:0] K1A = ADDR_W'(KEY1_ADDR);
  localparam logic [ADDR_W-1:0] CA  = ADDR_W'(CTRL_ADDR);
  localparam logic [DATA_W-1:0] K0V = DATA_W'(KEY0_VAL);
  localparam logic [DATA_W-1:0] K1V = DATA_W'(KEY1_VAL);
  localparam logic [DATA_W-1:0] STATUS_MASK = DATA_W'(1) << STATUS_BIT;

  logic hitKey0, hitKey1;

  assign hitKey0 = wrEn && (wrAddr == K0A);
  assign hitKey1 = wrEn && (wrAddr == K1A);

  assign evt.key0Good = hitKey0 && (wrData == K0V);
  assign evt.key0Bad  = hitKey0 && (wrData != K0V);
  assign evt.key1Good = hitKey1 && (wrData == K1V);
  assign evt.key1Bad  = hitKey1 && (wrData != K1V);

  assign protWrEn = wrEn && ctl.gateOpen && !hitKey0 && !hitKey1;
  assign rdData   = (rdAddr == CA && ctl.gateOpen) ? STATUS_MASK : '0;

  // R6
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.gateOpen |-> !protWrEn);
  // R7
  key_no_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == K0A || wrAddr == K1A)) |-> !protWrEn);
  // R9
  read_other_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr != CA) |-> (rdData == '0));
endmodule

// File: rtl/keygate_top.sv
module keygate_top
  import keygate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              protWrEn
);
  keyEvt_t  evt;
  gateCtl_t ctl;

  keygate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .ctl(ctl)
  );

  keygate_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .ctl(ctl), .evt(evt), .rdData(rdData), .protWrEn(protWrEn)
  );
endmodule

// File: tb/keygate_top_bench.sv
module keygate_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        protWrEn;

  int checks = 0;
  int fails  = 0;
  int refState = 0;   // 0 closed, 1 first key accepted, 2 open
  bit finished = 0;

  localparam logic [31:0] K0 = 32'h83E7_0B13;
  localparam logic [31:0] K1 = 32'h95A4_F1E0;

  always #2.5 clk = ~clk;

  keygate_top u_keygate_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .protWrEn(protWrEn)
  );

  task automatic compare(input string tag);
    logic        expWr;
    logic [31:0] expRd;
    expWr = wrEn && (refState == 2) && rstN && wrAddr != 8'h70 && wrAddr != 8'h74;
    expRd = (rdAddr == 8'h50 && refState == 2) ? (32'h1 << 23) : 32'h0;
    checks++;
    if (protWrEn !== expWr) begin
      fails++;
      $display("FAIL %s protWrEn actual=%b expected=%b", tag, protWrEn, expWr);
    end
    checks++;
    if (rdData !== expRd) begin
      fails++;
      $display("FAIL %s rdData actual=%h expected=%h", tag, rdData, expRd);
    end
  endtask

  // drive at negedge, compare, advance model at posedge
  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input logic [7:0] ra, input string tag);
    wrEn = we; wrAddr = a; wrData = d; rdAddr = ra;
    #1;
    compare(tag);
    @(posedge clk);
    if (we && rstN) begin
      case (refState)
        0: if (a == 8'h70 && d == K0) refState = 1;
        1: if (a == 8'h74 && d == K1) refState = 2;
           else if (a == 8'h70 && d != K0) refState = 0;
           else if (a == 8'h74) refState = 0;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; refState = 0;
    step(0, 8'h00, 0, 8'h50, "R1");
    step(1, 8'h10, 32'h1, 8'h50, "R1");
    rstN = 1'b1;
    step(0, 8'h00, 0, 8'h50, "R1");
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R6 closed gate drops writes
    step(1, 8'h50, 32'hFFFF_FFFF, 8'h50, "R6");
    step(1, 8'h10, 32'h1234, 8'h10, "R6");
    // R3 second key alone
    step(1, 8'h74, K1, 8'h50, "R3");
    step(0, 8'h00, 0, 8'h50, "R3");
    // R4 wrong first key then good second
    step(1, 8'h70, 32'hDEAD_BEEF, 8'h50, "R4");
    step(1, 8'h74, K1, 8'h50, "R4");
    step(0, 8'h00, 0, 8'h50, "R4");
    // R4 good first, wrong second, then good second
    step(1, 8'h70, K0, 8'h50, "R4");
    step(1, 8'h74, 32'h0, 8'h50, "R4");
    step(1, 8'h74, K1, 8'h50, "R4");
    step(0, 8'h00, 0, 8'h50, "R4");
    // R4 good first, wrong first, good second
    step(1, 8'h70, K0, 8'h50, "R4");
    step(1, 8'h70, K1, 8'h50, "R4");
    step(1, 8'h74, K1, 8'h50, "R4");
    step(0, 8'h00, 0, 8'h50, "R4");
    // R10 repeat good first, R5 unrelated writes, R2 open
    step(1, 8'h70, K0, 8'h50, "R10");
    step(1, 8'h70, K0, 8'h50, "R10");
    step(1, 8'h20, 32'h5555, 8'h50, "R5");
    step(1, 8'h50, 32'hAAAA, 8'h30, "R5");
    step(1, 8'h74, K1, 8'h50, "R2");
    step(0, 8'h00, 0, 8'h50, "R2");
    // R7 writes pass, key writes do not
    step(1, 8'h50, 32'h1, 8'h50, "R7");
    step(1, 8'h10, 32'h2, 8'h50, "R7");
    step(1, 8'h70, K0, 8'h50, "R7");
    step(1, 8'h74, 32'h0, 8'h50, "R7");
    step(0, 8'h10, 32'h2, 8'h50, "R7");
    // R8 wrong keys keep open
    step(1, 8'h70, 32'h0, 8'h50, "R8");
    step(1, 8'h74, 32'h0, 8'h50, "R8");
    step(0, 8'h00, 0, 8'h50, "R8");
    // R9 other addresses read zero
    step(0, 8'h00, 0, 8'h54, "R9");
    step(0, 8'h00, 0, 8'h70, "R9");
    step(0, 8'h00, 0, 8'h00, "R9");
    // R1 reset closes again
    doReset();
    step(1, 8'h10, 32'h9, 8'h50, "R1");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule